// File: doc/BRIEF.md
# Video Processor Host Port Interface

This block is the host side of a character-mode video display processor. The host sees two byte-wide ports. One is a data port that reads and writes video memory. The other is a control port: writes to it go into a two-byte command decoder, and reads from it return the status byte. A command pair either loads one of eight write-only control registers or sets up the single shared video-memory address.

The memory address is 14 bits wide and advances after every data-port access. A one-byte read-ahead buffer holds the next byte to be read. It is refilled after each data read, and it also captures each byte the host writes. On the memory side the block drives a request/acknowledge port, and `host_busy_o` stalls the host while a memory operation is outstanding.

Event pulses from the video pipeline feed the status flags: frame end, fifth sprite with its number, and sprite collision. The frame flag, together with an enable bit in control register 1, drives an active-low interrupt output. The control registers are exported to the rest of the display engine.

Top module: `vdp_host_port`

## Requirements
- R1: After reset, all control registers, the address, the read buffer, the host read data, the pairing state and all status flags are zero. `int_no` is 1, and `host_busy_o` and `vram_req_o` are 0.
- R2: A control-port write (`host_ctl_i`=1, `host_we_i`=1) that completes a pair, with bit 7 = 1, copies the first byte into the register indexed by bits 2:0. Bits 6:3 are ignored. The new value appears on `ctrl_regs_o[8*i+7:8*i]` one cycle after that write.
- R3: A completing control byte with bit 7 = 0 and bit 6 = 1 sets the address to {bits 5:0, first byte} and starts no memory access, so the read buffer keeps its value.
- R4: A completing control byte with bit 7 = 0 and bit 6 = 0 fetches the byte at {bits 5:0, first byte} into the read buffer and leaves the address at that value + 1.
- R5: A data-port read (`host_ctl_i`=0, `host_we_i`=0) puts the buffered byte on `host_rdata_o` one cycle later. It then fetches the byte at the current address into the buffer and increments the address.
- R6: A data-port write stores the byte at the current address, loads the same byte into the read buffer, and increments the address.
- R7: The address wraps from 3FFFh to 0000h.
- R8: A status read or any data-port access cancels a half-written control pair, so the next control write is again a first byte.
- R9: The status byte is {frame, fifth-sprite, collision, fifth-sprite number[4:0]} from bit 7 down to bit 0. A status read returns the value before the read and then clears the frame and collision bits. The fifth-sprite flag and number are held, and the number is captured on the first fifth-sprite event.
- R10: `frame_end_i` sets the frame flag. If a status read falls in the same cycle, the read returns the old value and the flag is left set.
- R11: `int_no` is 0 exactly while the frame flag and bit 5 of control register 1 are both 1. Enabling the interrupt while the flag is pending pulls `int_no` low in the cycle after the enabling write.
- R12: `host_busy_o` is high from the cycle after a memory operation is issued until the acknowledge. While it is high, a host access is not taken and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_sel_i | input | 1 | Host access strobe, one cycle per access |
| host_ctl_i | input | 1 | 1 = control/status port, 0 = data port |
| host_we_i | input | 1 | 1 = write, 0 = read |
| host_wdata_i | input | 8 | Host write byte |
| host_rdata_o | output | 8 | Host read byte, valid one cycle after the read |
| host_busy_o | output | 1 | Memory operation outstanding; accesses are held off |
| vram_req_o | output | 1 | Memory request, held until acknowledged |
| vram_we_o | output | 1 | Memory request is a write |
| vram_addr_o | output | 14 | Memory address |
| vram_wdata_o | output | 8 | Memory write byte |
| vram_ack_i | input | 1 | Memory acknowledge |
| vram_rdata_i | input | 8 | Memory read byte, valid with acknowledge |
| frame_end_i | input | 1 | Pulse at the end of the last active line |
| spr_fifth_i | input | 1 | Fifth-sprite event |
| spr_fifth_num_i | input | 5 | Sprite number for the fifth-sprite event |
| spr_coll_i | input | 1 | Sprite collision event |
| ctrl_regs_o | output | 64 | Control registers 0 to 7, register i in bits 8i+7:8i |
| int_no | output | 1 | Interrupt request, active low |

## Verification
Host read data is due one cycle after the accepting edge, and register values are due one cycle after the completing control write. The interrupt follows its causes one cycle after the edge that changes the register or flag. A memory fetch or store lands after an acknowledge delay that the memory model varies from two to eight cycles. The bench drives every access at a falling edge and samples the results at the next falling edge. Before a new access it waits for `host_busy_o` to drop, so the reference model only has to compare state once all outstanding memory work has retired. The stall case deliberately places an access inside the busy window and then shows through the following reads that the access had no effect.

// File: rtl/vdp_host_pkg.sv
package vdp_host_pkg;
  localparam int unsigned ADDR_W     = 14;
  localparam int unsigned DATA_W     = 8;
  localparam int unsigned NUM_REGS   = 8;
  localparam int unsigned SNUM_W     = 5;
  localparam int unsigned INT_EN_REG = 1;
  localparam int unsigned INT_EN_BIT = 5;

  typedef enum logic [1:0] {
    CMD_NONE   = 2'd0,
    CMD_SET_WR = 2'd1,
    CMD_SET_RD = 2'd2
  } addr_cmd_e;
endpackage

// File: rtl/vdp_ctl_decode.sv
module vdp_ctl_decode
  import vdp_host_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = NUM_REGS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               acc_i,
  input  logic               ctl_i,
  input  logic               we_i,
  input  logic [DW-1:0]      wdata_i,
  output addr_cmd_e          cmd_o,
  output logic [AW-1:0]      cmd_addr_o,
  output logic [NREG*DW-1:0] regs_o
);
  localparam int unsigned IW = $clog2(NREG);
  localparam int unsigned HW = AW - DW;

  logic          pair_q;
  logic [DW-1:0] lo_q;
  logic          ctl_wr, second, reg_wr;

  assign ctl_wr = acc_i & ctl_i & we_i;
  assign second = ctl_wr & pair_q;
  assign reg_wr = second & wdata_i[DW-1];

  always_comb begin
    cmd_o = CMD_NONE;
    if (second && !wdata_i[DW-1]) cmd_o = wdata_i[DW-2] ? CMD_SET_WR : CMD_SET_RD;
  end
  assign cmd_addr_o = {wdata_i[HW-1:0], lo_q};

  // pairing: any other accepted access drops a half-written pair
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pair_q <= 1'b0;
      lo_q   <= '0;
    end else if (ctl_wr) begin
      pair_q <= ~pair_q;
      if (!pair_q) lo_q <= wdata_i;
    end else if (acc_i) begin
      pair_q <= 1'b0;
    end
  end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] r_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) r_q <= '0;
      else if (reg_wr && wdata_i[IW-1:0] == IW'(g)) r_q <= lo_q;
    end
    assign regs_o[g*DW +: DW] = r_q;
  end

  p_reg_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr |=> $stable(regs_o));
  p_pair_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_i && !(ctl_i && we_i)) |=> !pair_q);
  p_cmd_second_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_o != CMD_NONE) |-> (pair_q && acc_i));
endmodule

// File: rtl/vdp_vram_xfer.sv
module vdp_vram_xfer
  import vdp_host_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned DW = DATA_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          acc_i,
  input  logic          ctl_i,
  input  logic          we_i,
  input  logic [DW-1:0] wdata_i,
  input  addr_cmd_e     cmd_i,
  input  logic [AW-1:0] cmd_addr_i,
  output logic [DW-1:0] buf_o,
  output logic          busy_o,
  output logic          vram_req_o,
  output logic          vram_we_o,
  output logic [AW-1:0] vram_addr_o,
  output logic [DW-1:0] vram_wdata_o,
  input  logic          vram_ack_i,
  input  logic [DW-1:0] vram_rdata_i
);
  logic [AW-1:0] addr_q;
  logic [DW-1:0] buf_q;
  logic          dat_rd, dat_wr;

  assign dat_rd = acc_i & ~ctl_i & ~we_i;
  assign dat_wr = acc_i & ~ctl_i & we_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q       <= '0;
      buf_q        <= '0;
      vram_req_o   <= 1'b0;
      vram_we_o    <= 1'b0;
      vram_addr_o  <= '0;
      vram_wdata_o <= '0;
    end else if (cmd_i == CMD_SET_WR) begin
      addr_q <= cmd_addr_i;
    end else if (cmd_i == CMD_SET_RD) begin
      vram_req_o  <= 1'b1;
      vram_we_o   <= 1'b0;
      vram_addr_o <= cmd_addr_i;
      addr_q      <= cmd_addr_i + 1'b1;
    end else if (dat_rd) begin
      vram_req_o  <= 1'b1;
      vram_we_o   <= 1'b0;
      vram_addr_o <= addr_q;
      addr_q      <= addr_q + 1'b1;
    end else if (dat_wr) begin
      vram_req_o   <= 1'b1;
      vram_we_o    <= 1'b1;
      vram_addr_o  <= addr_q;
      vram_wdata_o <= wdata_i;
      buf_q        <= wdata_i;
      addr_q       <= addr_q + 1'b1;
    end else if (vram_req_o && vram_ack_i) begin
      vram_req_o <= 1'b0;
      if (!vram_we_o) buf_q <= vram_rdata_i;
    end
  end

  assign buf_o  = buf_q;
  assign busy_o = vram_req_o;

  p_req_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vram_req_o && !vram_ack_i) |=> (vram_req_o && $stable(vram_addr_o) && $stable(vram_we_o)));
  p_addr_step_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_rd || dat_wr) |=> (addr_q == AW'($past(addr_q) + 1'b1)));
  p_wrap_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dat_rd || dat_wr) && addr_q == {AW{1'b1}}) |=> (addr_q == '0));
  p_wr_buf_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dat_wr |=> (buf_q == $past(wdata_i) && vram_we_o));
  p_set_nofetch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_SET_WR) |=> $stable(buf_q));
endmodule

// File: rtl/vdp_status.sv
module vdp_status
  import vdp_host_pkg::*;
#(
  parameter int unsigned NW = SNUM_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          rd_i,
  input  logic          frame_end_i,
  input  logic          fifth_i,
  input  logic [NW-1:0] fifth_num_i,
  input  logic          coll_i,
  input  logic          int_en_i,
  output logic [NW+2:0] status_o,
  output logic          int_no
);
  logic          frame_q, fifth_q, coll_q;
  logic [NW-1:0] num_q;

  // a new event outranks the clear from a same-cycle read
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= 1'b0;
      coll_q  <= 1'b0;
      fifth_q <= 1'b0;
      num_q   <= '0;
    end else begin
      if (frame_end_i)  frame_q <= 1'b1;
      else if (rd_i)    frame_q <= 1'b0;
      if (coll_i)       coll_q  <= 1'b1;
      else if (rd_i)    coll_q  <= 1'b0;
      if (fifth_i && !fifth_q) begin
        fifth_q <= 1'b1;
        num_q   <= fifth_num_i;
      end
    end
  end

  assign status_o = {frame_q, fifth_q, coll_q, num_q};
  assign int_no   = ~(frame_q & int_en_i);

  p_frame_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_end_i |=> status_o[NW+2]);
  p_rd_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frame_end_i && !coll_i) |=> (!status_o[NW+2] && !status_o[NW]));
  p_fifth_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[NW+1] |=> (status_o[NW+1] && $stable(status_o[NW-1:0])));
  p_int_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_no |-> (status_o[NW+2] && int_en_i));
endmodule

// File: rtl/vdp_host_port.sv
module vdp_host_port
  import vdp_host_pkg::*;
#(
  parameter int unsigned AW   = ADDR_W,
  parameter int unsigned DW   = DATA_W,
  parameter int unsigned NREG = NUM_REGS,
  parameter int unsigned NW   = SNUM_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_sel_i,
  input  logic               host_ctl_i,
  input  logic               host_we_i,
  input  logic [DW-1:0]      host_wdata_i,
  output logic [DW-1:0]      host_rdata_o,
  output logic               host_busy_o,
  output logic               vram_req_o,
  output logic               vram_we_o,
  output logic [AW-1:0]      vram_addr_o,
  output logic [DW-1:0]      vram_wdata_o,
  input  logic               vram_ack_i,
  input  logic [DW-1:0]      vram_rdata_i,
  input  logic               frame_end_i,
  input  logic               spr_fifth_i,
  input  logic [NW-1:0]      spr_fifth_num_i,
  input  logic               spr_coll_i,
  output logic [NREG*DW-1:0] ctrl_regs_o,
  output logic               int_no
);
  logic          acc, st_rd, busy;
  addr_cmd_e     cmd;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] rd_buf;
  logic [NW+2:0] status;

  assign acc   = host_sel_i & ~busy;
  assign st_rd = acc & host_ctl_i & ~host_we_i;

  vdp_ctl_decode #(.AW(AW), .DW(DW), .NREG(NREG)) u_ctl (
    .clk_i, .rst_ni, .acc_i(acc), .ctl_i(host_ctl_i), .we_i(host_we_i),
    .wdata_i(host_wdata_i), .cmd_o(cmd), .cmd_addr_o(cmd_addr), .regs_o(ctrl_regs_o)
  );

  vdp_vram_xfer #(.AW(AW), .DW(DW)) u_xfer (
    .clk_i, .rst_ni, .acc_i(acc), .ctl_i(host_ctl_i), .we_i(host_we_i),
    .wdata_i(host_wdata_i), .cmd_i(cmd), .cmd_addr_i(cmd_addr), .buf_o(rd_buf),
    .busy_o(busy), .vram_req_o, .vram_we_o, .vram_addr_o, .vram_wdata_o,
    .vram_ack_i, .vram_rdata_i
  );

  vdp_status #(.NW(NW)) u_status (
    .clk_i, .rst_ni, .rd_i(st_rd), .frame_end_i, .fifth_i(spr_fifth_i),
    .fifth_num_i(spr_fifth_num_i), .coll_i(spr_coll_i),
    .int_en_i(ctrl_regs_o[INT_EN_REG*DW + INT_EN_BIT]), .status_o(status), .int_no
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_rdata_o <= '0;
    else if (acc && !host_we_i) host_rdata_o <= host_ctl_i ? DW'(status) : rd_buf;
  end

  assign host_busy_o = busy;

  p_busy_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_busy_o && !vram_ack_i) |=> host_busy_o);
  p_rdata_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(host_sel_i && !host_busy_o && !host_we_i) |=> $stable(host_rdata_o));
endmodule

// File: tb/vdp_host_port_bench.sv
`timescale 1ns/1ps
module vdp_host_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, hctl = 1'b0, hwe = 1'b0;
  logic [7:0]  hwd = '0;
  logic [7:0]  hrd;
  logic        busy, req, vwe, ack = 1'b0;
  logic [13:0] vaddr;
  logic [7:0]  vwd, vrd = '0;
  logic        frame = 1'b0, fifth = 1'b0, coll = 1'b0;
  logic [4:0]  fnum = '0;
  logic [63:0] regs;
  logic        int_n;

  always #2 clk = ~clk;

  vdp_host_port u_vdp_host_port (
    .clk_i(clk), .rst_ni(rst_n), .host_sel_i(sel), .host_ctl_i(hctl), .host_we_i(hwe),
    .host_wdata_i(hwd), .host_rdata_o(hrd), .host_busy_o(busy), .vram_req_o(req),
    .vram_we_o(vwe), .vram_addr_o(vaddr), .vram_wdata_o(vwd), .vram_ack_i(ack),
    .vram_rdata_i(vrd), .frame_end_i(frame), .spr_fifth_i(fifth), .spr_fifth_num_i(fnum),
    .spr_coll_i(coll), .ctrl_regs_o(regs), .int_no(int_n)
  );

  // memory model with variable acknowledge delay
  logic [7:0] mem [16384];
  int lat = 1;
  int cnt = 0;
  logic inflight = 1'b0;
  always @(posedge clk) begin
    ack <= 1'b0;
    if (req && !ack) begin
      if (!inflight) begin
        inflight <= 1'b1;
        cnt <= lat;
      end else if (cnt == 0) begin
        inflight <= 1'b0;
        ack <= 1'b1;
        vrd <= mem[vaddr];
        if (vwe) mem[vaddr] <= vwd;
      end else cnt <= cnt - 1;
    end
  end

  // reference state
  logic [7:0]  e_mem [16384];
  logic [7:0]  e_reg [8];
  logic [13:0] e_addr = '0;
  logic [7:0]  e_buf = '0, e_lo = '0;
  logic        e_pair = 1'b0, e_frame = 1'b0, e_fifth = 1'b0, e_coll = 1'b0;
  logic [4:0]  e_num = '0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  function automatic logic [63:0] pack_regs();
    logic [63:0] v;
    for (int i = 0; i < 8; i++) v[i*8 +: 8] = e_reg[i];
    return v;
  endfunction

  function automatic logic exp_int();
    return !(e_frame && e_reg[1][5]);
  endfunction

  task automatic chk(input string req_s, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req_s, act, exp);
    end
  endtask

  task automatic acc(input logic c, input logic w, input logic [7:0] d);
    @(negedge clk);
    while (busy) @(negedge clk);
    sel = 1'b1; hctl = c; hwe = w; hwd = d;
    @(negedge clk);
    sel = 1'b0; hwe = 1'b0;
  endtask

  task automatic ref_ctl(input logic [7:0] d);
    logic [13:0] a;
    if (!e_pair) begin
      e_lo = d; e_pair = 1'b1;
    end else begin
      e_pair = 1'b0;
      if (d[7]) e_reg[d[2:0]] = e_lo;
      else begin
        a = {d[5:0], e_lo};
        if (d[6]) e_addr = a;
        else begin
          e_buf = e_mem[a]; e_addr = a + 14'd1;
        end
      end
    end
  endtask

  task automatic ctl_wr(input logic [7:0] d);
    acc(1'b1, 1'b1, d);
    ref_ctl(d);
  endtask

  task automatic dat_wr(input logic [7:0] d);
    acc(1'b0, 1'b1, d);
    e_mem[e_addr] = d; e_buf = d; e_addr = e_addr + 14'd1; e_pair = 1'b0;
  endtask

  task automatic dat_rd(input string req_s);
    logic [7:0] x;
    acc(1'b0, 1'b0, 8'h00);
    x = e_buf; e_buf = e_mem[e_addr]; e_addr = e_addr + 14'd1; e_pair = 1'b0;
    chk(req_s, 64'(hrd), 64'(x));
  endtask

  function automatic logic [7:0] ref_st();
    logic [7:0] x;
    x = {e_frame, e_fifth, e_coll, e_num};
    e_frame = 1'b0; e_coll = 1'b0; e_pair = 1'b0;
    return x;
  endfunction

  task automatic st_rd(input string req_s);
    logic [7:0] x;
    acc(1'b1, 1'b0, 8'h00);
    x = ref_st();
    chk(req_s, 64'(hrd), 64'(x));
  endtask

  task automatic pulse_frame();
    @(negedge clk); frame = 1'b1;
    @(negedge clk); frame = 1'b0;
    e_frame = 1'b1;
  endtask

  task automatic settle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R12 watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] x;
    void'($urandom(32'h5eed_0918));
    for (int i = 0; i < 16384; i++) begin
      x = 8'($urandom);
      mem[i] = x; e_mem[i] = x;
    end
    for (int i = 0; i < 8; i++) e_reg[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 regs", regs, 64'h0);
    chk("R1 int_no", 64'(int_n), 64'h1);
    chk("R1 busy", 64'(busy), 64'h0);
    chk("R1 req", 64'(req), 64'h0);
    chk("R1 rdata", 64'(hrd), 64'h0);
    st_rd("R1 status");

    // R2 register write, bits 6:3 ignored
    ctl_wr(8'hAA); ctl_wr(8'hFB);
    chk("R2 reg3", 64'(regs[31:24]), 64'hAA);
    chk("R2 all", regs, pack_regs());

    // R3 write-address setup, no fetch
    ctl_wr(8'h00); ctl_wr(8'h6A);
    settle();
    chk("R3 no req", 64'(req), 64'h0);
    dat_rd("R3 buffer kept");
    ctl_wr(8'h00); ctl_wr(8'h6A);
    dat_wr(8'h99);
    ctl_wr(8'h00); ctl_wr(8'h2A);
    dat_rd("R3 stored at set address");

    // R4 read setup then R5 sequential reads
    ctl_wr(8'h34); ctl_wr(8'h12);
    dat_rd("R4 fetch at 1234h");
    dat_rd("R5 next byte");

    // R6 write reloads the buffer
    dat_wr(8'h5C);
    dat_rd("R6 buffer holds written byte");

    // R7 wrap
    ctl_wr(8'hFF); ctl_wr(8'h7F);
    dat_wr(8'h5A); dat_wr(8'hA5);
    ctl_wr(8'h00); ctl_wr(8'h00);
    dat_rd("R7 wrapped to 0000h");
    chk("R7 direct", 64'(hrd), 64'hA5);

    // R8 pairing cancelled
    ctl_wr(8'h07); st_rd("R8 status");
    ctl_wr(8'h3C); ctl_wr(8'h87);
    chk("R8 after status read", 64'(regs[63:56]), 64'h3C);
    ctl_wr(8'h11); dat_wr(8'h22);
    ctl_wr(8'h44); ctl_wr(8'h82);
    chk("R8 after data write", 64'(regs[23:16]), 64'h44);

    // R9 status fields
    @(negedge clk); fifth = 1'b1; fnum = 5'h13; coll = 1'b1;
    @(negedge clk); fifth = 1'b0; coll = 1'b0;
    e_fifth = 1'b1; e_num = 5'h13; e_coll = 1'b1;
    @(negedge clk); fifth = 1'b1; fnum = 5'h07;
    @(negedge clk); fifth = 1'b0;
    st_rd("R9 status with flags");
    chk("R9 value", 64'(hrd), 64'h73);
    st_rd("R9 collision cleared");

    // R10 frame set wins over same-cycle read
    settle();
    sel = 1'b1; hctl = 1'b1; hwe = 1'b0; frame = 1'b1;
    @(negedge clk);
    sel = 1'b0; frame = 1'b0;
    x = ref_st(); e_frame = 1'b1;
    chk("R10 read returns old", 64'(hrd), 64'(x));
    st_rd("R10 frame kept");
    chk("R10 frame bit", 64'(hrd[7]), 64'h1);

    // R11 interrupt
    ctl_wr(8'h00); ctl_wr(8'h81);
    pulse_frame();
    chk("R11 masked", 64'(int_n), 64'h1);
    ctl_wr(8'h20); ctl_wr(8'h81);
    chk("R11 enable while pending", 64'(int_n), 64'h0);
    st_rd("R11 status");
    chk("R11 released by read", 64'(int_n), 64'h1);

    // R12 stall
    ctl_wr(8'h00); ctl_wr(8'h41);
    dat_wr(8'h11); dat_wr(8'h22);
    ctl_wr(8'h00); ctl_wr(8'h01);
    settle();
    lat = 6;
    dat_rd("R12 first read");
    chk("R12 busy high", 64'(busy), 64'h1);
    sel = 1'b1; hctl = 1'b0; hwe = 1'b1; hwd = 8'hEE;
    @(negedge clk);
    sel = 1'b0; hwe = 1'b0;
    settle();
    chk("R12 busy released", 64'(busy), 64'h0);
    dat_rd("R12 stalled write ignored");
    chk("R12 value", 64'(hrd), 64'h22);

    // constrained random mix
    for (int k = 0; k < 400; k++) begin
      int op;
      logic [7:0] r;
      lat = int'($urandom % 3);
      op = int'($urandom % 8);
      r = 8'($urandom);
      case (op)
        0, 1: dat_wr(r);
        2, 3: dat_rd("R5 random read");
        4: st_rd("R9 random status");
        5: begin
          ctl_wr(r);
          ctl_wr({1'b1, 4'($urandom), 3'($urandom)});
          chk("R2 random register", regs, pack_regs());
        end
        6: begin
          ctl_wr(r);
          ctl_wr({1'b0, 1'($urandom), 6'($urandom)});
        end
        default: if (r[0]) pulse_frame(); else ctl_wr(r);
      endcase
      @(negedge clk);
      chk("R11 random int", 64'(int_n), 64'(exp_int()));
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule